// File: doc/BRIEF.md
# Byte ALU with Status Flag Generation

This block is the arithmetic and logic unit of a small eight-bit RISC-style processor core. Each accepted request carries an operation code, a destination operand, a source operand or immediate, the current carry flag and the current zero flag. The block returns one registered result byte together with the next value of six status flags and a write enable for each flag. Every operation changes only its own set of flags, so the core can merge the new flags into its status register without any decode of its own.

Byte operations finish one clock after they are accepted. The two word operations add an immediate to, or subtract it from, a sixteen-bit register pair. They take two cycles: the low byte goes through the shared adder in the first cycle and the high byte in the second. While the second cycle runs, the block shows busy and ignores new requests. Compare operations set the flags but mark the result as not to be written back.

Top module: `alu8_flags`

## Requirements
- R1: `op_i` codes are ADD 0, ADD-with-carry 1, SUB 2, SUB-with-carry 3, compare 4, compare-with-carry 5, AND 6, OR 7, XOR 8, complement 9, negate 10, increment 11, decrement 12, shift left 13, logical shift right 14, rotate left through carry 15, rotate right through carry 16, arithmetic shift right 17, nibble swap 18, set-all 19, word add 20, word subtract 21. The flag vectors use the bit order C=0, Z=1, N=2, V=3, S=4, H=5. A byte operation accepted at one rising edge raises `out_valid_o` for exactly one cycle after that edge.
- R2: ADD, ADD-with-carry, SUB and SUB-with-carry enable all six flags. C is the carry (or borrow) out of bit 7, H is the carry (or borrow) out of bit 3, V is two's-complement overflow and N is result bit 7.
- R3: For SUB-with-carry and compare-with-carry, Z becomes `z_in_i` when the result is zero and 0 otherwise. All other operations set Z from the zero test of their result alone.
- R4: The two compare operations update flags exactly as SUB and SUB-with-carry do, and drive `res_wr_o` low. All other defined byte operations drive it high.
- R5: AND, OR and XOR enable only S, V, N and Z, and always produce V=0.
- R6: Complement gives 0xFF minus the operand, enables S, V, N, Z and C, and forces C=1 and V=0. Negate gives 0x00 minus the operand and enables all six flags: C=1 unless the result is zero, V=1 only for 0x80, H is the borrow out of bit 3.
- R7: Increment and decrement enable S, V, N and Z but never C. V is set when increment gives 0x80 or decrement gives 0x7F.
- R8: Shift left and rotate left move bit 7 into C and put 0 or `c_in_i` into bit 0, with H equal to operand bit 3 and all six flags enabled. Logical shift right, rotate right and arithmetic shift right move bit 0 into C and fill bit 7 with 0, `c_in_i` or the old bit 7, enabling S, V, N, Z and C. For every shift, V = N xor C.
- R9: Nibble swap exchanges the two halves of the operand, and set-all returns 0xFF. Neither enables any flag.
- R10: A word operation forms {`pair_hi_i`,`opa_i`} ± `opb_i`. `busy_o` is high for exactly the one cycle after acceptance. The sixteen-bit result appears on `res_hi_o`:`res_lo_o` with `out_valid_o` one cycle later. S, V, N, Z and C are enabled and taken from the 16-bit result: Z only if both bytes are zero, C as carry or borrow out of bit 15.
- R11: Whenever S is enabled it equals N xor V.
- R12: A request presented while `busy_o` is high produces no result. Codes 22 to 31 produce an `out_valid_o` pulse with no flag enables and `res_wr_o` low.
- R13: While reset is held, and after it is released, `out_valid_o`, `busy_o` and `flag_we_o` are all zero until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Destination operand, or low byte of the pair |
| opb_i | input | 8 | Source operand or immediate |
| pair_hi_i | input | 8 | High byte of the register pair for word operations |
| c_in_i | input | 1 | Current carry flag |
| z_in_i | input | 1 | Current zero flag |
| busy_o | output | 1 | Word operation in its second cycle |
| out_valid_o | output | 1 | Result and flags valid for one cycle |
| res_lo_o | output | 8 | Result byte, or low byte of a word result |
| res_hi_o | output | 8 | High byte of a word result, zero otherwise |
| res_wr_o | output | 1 | Result is to be written back |
| flag_nxt_o | output | 6 | Next flag values, bit order C Z N V S H |
| flag_we_o | output | 6 | Per-flag update enables, same order |

## Verification
The hardest state to reach from the ports is a request that arrives during the second cycle of a word operation. The stimulus starts a word add and, on the very next clock, offers a set-all request. It then checks that the word result is intact and that no further valid pulse follows. The chained zero rule is also hard to reach, because it needs a zero result from subtract-with-carry with `z_in_i` both high and low. The stimulus drives operand pairs that give a zero result with either value of the incoming zero flag, and one pair that gives a nonzero result.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int OP_W   = 5;
  localparam int FL_CNT = 6;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,  OP_ADDC  = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
    OP_CMP   = 5'd4,  OP_CMPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR   = 5'd8,  OP_INV   = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC   = 5'd12, OP_SHL   = 5'd13, OP_SHR  = 5'd14, OP_RCL  = 5'd15,
    OP_RCR   = 5'd16, OP_SAR   = 5'd17, OP_NSWAP = 5'd18, OP_ONES = 5'd19,
    OP_WADD  = 5'd20, OP_WSUB  = 5'd21
  } alu_op_e;

  // Enable masks, bit order H S V N Z C
  localparam logic [FL_CNT-1:0] WE_ALL   = 6'b111111;
  localparam logic [FL_CNT-1:0] WE_SVNZ  = 6'b011110;
  localparam logic [FL_CNT-1:0] WE_SVNZC = 6'b011111;
  localparam logic [FL_CNT-1:0] WE_NONE  = 6'b000000;

  typedef enum logic {PH_BYTE = 1'b0, PH_WHI = 1'b1} phase_e;
endpackage

// File: rtl/alu8_rst_sync.sv
`timescale 1ns/1ps
module alu8_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              hc_o,
  output logic              ov_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W:0] full;
  logic [NIB_W:0]  nib;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    end
  end

  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
  assign hc_o   = nib[NIB_W];
  // Overflow: operand signs agree (add) or differ (sub) and result sign leaves a
  assign ov_o   = (sub_i ? (a_i[MSB] ^ b_i[MSB]) : ~(a_i[MSB] ^ b_i[MSB]))
                  & (sum_o[MSB] ^ a_i[MSB]);
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              hbit_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] swapped;

  for (genvar i = 0; i < NIB_W; i++) begin : g_swap
    assign swapped[i]         = a_i[i + NIB_W];
    assign swapped[i + NIB_W] = a_i[i];
  end

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_INV: begin
        res_o  = ~a_i;
        cout_o = 1'b1;
      end
      OP_SHL: begin
        res_o  = {a_i[MSB-1:0], 1'b0};
        cout_o = a_i[MSB];
      end
      OP_RCL: begin
        res_o  = {a_i[MSB-1:0], cin_i};
        cout_o = a_i[MSB];
      end
      OP_SHR: begin
        res_o  = {1'b0, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_RCR: begin
        res_o  = {cin_i, a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_SAR: begin
        res_o  = {a_i[MSB], a_i[MSB:1]};
        cout_o = a_i[0];
      end
      OP_NSWAP: res_o = swapped;
      OP_ONES:  res_o = '1;
      default:  res_o = '0;
    endcase
  end

  // Left shifts report the bit leaving the low nibble as half carry
  assign hbit_o = a_i[NIB_W-1];
endmodule

// File: rtl/alu8_flagmux.sv
`timescale 1ns/1ps
module alu8_flagmux
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              as_c_i,
  input  logic              as_h_i,
  input  logic              as_v_i,
  input  logic [DATA_W-1:0] bit_res_i,
  input  logic              bit_c_i,
  input  logic              bit_h_i,
  input  logic              z_in_i,
  input  logic              lo_zero_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FL_CNT-1:0] flag_o,
  output logic [FL_CNT-1:0] we_o,
  output logic              wr_o
);
  localparam int MSB = DATA_W - 1;

  logic c_f, z_f, n_f, v_f, h_f;
  logic res_zero;

  assign res_zero = (res_o == '0);

  always_comb begin
    res_o = sum_i;
    c_f   = 1'b0;
    h_f   = 1'b0;
    v_f   = 1'b0;
    we_o  = WE_NONE;
    wr_o  = 1'b1;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG: begin
        c_f  = as_c_i;
        h_f  = as_h_i;
        v_f  = as_v_i;
        we_o = WE_ALL;
        wr_o = !(op_i == OP_CMP || op_i == OP_CMPC);
      end
      OP_INC, OP_DEC: begin
        v_f  = as_v_i;
        we_o = WE_SVNZ;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o = bit_res_i;
        we_o  = WE_SVNZ;
      end
      OP_INV: begin
        res_o = bit_res_i;
        c_f   = bit_c_i;
        we_o  = WE_SVNZC;
      end
      OP_SHL, OP_RCL: begin
        res_o = bit_res_i;
        c_f   = bit_c_i;
        h_f   = bit_h_i;
        v_f   = bit_res_i[MSB] ^ bit_c_i;
        we_o  = WE_ALL;
      end
      OP_SHR, OP_RCR, OP_SAR: begin
        res_o = bit_res_i;
        c_f   = bit_c_i;
        v_f   = bit_res_i[MSB] ^ bit_c_i;
        we_o  = WE_SVNZC;
      end
      OP_NSWAP, OP_ONES: begin
        res_o = bit_res_i;
      end
      OP_WADD, OP_WSUB: begin
        c_f  = as_c_i;
        v_f  = as_v_i;
        we_o = WE_SVNZC;
      end
      default: begin
        res_o = '0;
        wr_o  = 1'b0;
      end
    endcase
  end

  always_comb begin
    n_f = res_o[MSB];
    if (op_i == OP_SUBC || op_i == OP_CMPC)
      z_f = res_zero & z_in_i;
    else if (op_i == OP_WADD || op_i == OP_WSUB)
      z_f = res_zero & lo_zero_i;
    else
      z_f = res_zero;
    flag_o        = '0;
    flag_o[FL_C]  = c_f;
    flag_o[FL_Z]  = z_f;
    flag_o[FL_N]  = n_f;
    flag_o[FL_V]  = v_f;
    flag_o[FL_S]  = n_f ^ v_f;
    flag_o[FL_H]  = h_f;
  end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] pair_hi_i,
  input  logic              c_in_i,
  input  logic              z_in_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic              res_wr_o,
  output logic [FL_CNT-1:0] flag_nxt_o,
  output logic [FL_CNT-1:0] flag_we_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic rst_s;

  // Registered state
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              wc_q, wc_d, wsub_q, wsub_d;
  logic              vld_q, vld_d, wr_q, wr_d;
  logic [DATA_W-1:0] rlo_q, rlo_d, rhi_q, rhi_d;
  logic [FL_CNT-1:0] flg_q, flg_d, we_q, we_d;

  // Datapath nets
  logic [OP_W-1:0]   op_eff;
  logic [DATA_W-1:0] add_a, add_b, sum;
  logic              add_cin, add_sub, as_c, as_h, as_v;
  logic [DATA_W-1:0] bit_res, cmb_res;
  logic              bit_c, bit_h, cmb_wr;
  logic [FL_CNT-1:0] cmb_flag, cmb_we;
  logic              in_word, take_byte, take_word, load_out;

  alu8_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_s)
  );

  assign busy_o    = (phase_q == PH_WHI);
  assign in_word   = (op_i == OP_WADD) || (op_i == OP_WSUB);
  assign take_byte = in_valid_i && !busy_o && !in_word;
  assign take_word = in_valid_i && !busy_o && in_word;
  assign load_out  = take_byte || busy_o;

  // Operand routing into the shared adder
  always_comb begin
    op_eff  = op_i;
    add_a   = opa_i;
    add_b   = opb_i;
    add_cin = 1'b0;
    add_sub = 1'b0;
    if (busy_o) begin
      op_eff  = wsub_q ? OP_WSUB : OP_WADD;
      add_a   = hi_q;
      add_b   = '0;
      add_cin = wc_q;
      add_sub = wsub_q;
    end else begin
      case (op_i)
        OP_ADDC:          add_cin = c_in_i;
        OP_SUB, OP_CMP:   add_sub = 1'b1;
        OP_SUBC, OP_CMPC: begin
          add_sub = 1'b1;
          add_cin = c_in_i;
        end
        OP_NEG: begin
          add_a   = '0;
          add_b   = opa_i;
          add_sub = 1'b1;
        end
        OP_INC:  add_b = ONE;
        OP_DEC: begin
          add_b   = ONE;
          add_sub = 1'b1;
        end
        OP_WSUB: add_sub = 1'b1;
        default: add_sub = 1'b0;
      endcase
    end
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin), .sub_i(add_sub),
    .sum_o(sum), .cout_o(as_c), .hc_o(as_h), .ov_o(as_v)
  );

  alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i(op_i), .a_i(opa_i), .b_i(opb_i), .cin_i(c_in_i),
    .res_o(bit_res), .cout_o(bit_c), .hbit_o(bit_h)
  );

  alu8_flagmux #(.DATA_W(DATA_W)) u_flagmux (
    .op_i(op_eff), .sum_i(sum), .as_c_i(as_c), .as_h_i(as_h), .as_v_i(as_v),
    .bit_res_i(bit_res), .bit_c_i(bit_c), .bit_h_i(bit_h),
    .z_in_i(z_in_i), .lo_zero_i(lo_q == '0),
    .res_o(cmb_res), .flag_o(cmb_flag), .we_o(cmb_we), .wr_o(cmb_wr)
  );

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    wc_d    = wc_q;
    wsub_d  = wsub_q;
    rlo_d   = rlo_q;
    rhi_d   = rhi_q;
    flg_d   = flg_q;
    we_d    = we_q;
    wr_d    = wr_q;
    vld_d   = load_out;
    if (take_word) begin
      phase_d = PH_WHI;
      hi_d    = pair_hi_i;
      lo_d    = sum;
      wc_d    = as_c;
      wsub_d  = (op_i == OP_WSUB);
    end else if (busy_o) begin
      phase_d = PH_BYTE;
    end
    if (load_out) begin
      rlo_d = busy_o ? lo_q : cmb_res;
      rhi_d = busy_o ? cmb_res : '0;
      flg_d = cmb_flag;
      we_d  = cmb_we;
      wr_d  = busy_o ? 1'b1 : cmb_wr;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      phase_q <= PH_BYTE;
      hi_q    <= '0;
      lo_q    <= '0;
      wc_q    <= 1'b0;
      wsub_q  <= 1'b0;
      vld_q   <= 1'b0;
      rlo_q   <= '0;
      rhi_q   <= '0;
      flg_q   <= '0;
      we_q    <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      wc_q    <= wc_d;
      wsub_q  <= wsub_d;
      vld_q   <= vld_d;
      rlo_q   <= rlo_d;
      rhi_q   <= rhi_d;
      flg_q   <= flg_d;
      we_q    <= we_d;
      wr_q    <= wr_d;
    end
  end

  assign out_valid_o = vld_q;
  assign res_lo_o    = rlo_q;
  assign res_hi_o    = rhi_q;
  assign res_wr_o    = wr_q;
  assign flag_nxt_o  = flg_q;
  assign flag_we_o   = we_q;

  // Protocol and flag-subset checks
  assert_word_start_R10: assert property (@(posedge clk_i) disable iff (!rst_s)
    take_word |=> (busy_o && !out_valid_o))
    else $error("word op did not enter second cycle");

  assert_word_finish_R10: assert property (@(posedge clk_i) disable iff (!rst_s)
    busy_o |=> (out_valid_o && !busy_o))
    else $error("word op did not finish after two cycles");

  assert_quiet_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_s)
    busy_o |-> !out_valid_o)
    else $error("result reported during word second cycle");

  assert_no_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_s)
    (take_byte && (op_i == OP_NSWAP || op_i == OP_ONES)) |=>
      (out_valid_o && flag_we_o == '0))
    else $error("swap or set-all enabled a flag");

  assert_keep_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_s)
    (take_byte && (op_i == OP_INC || op_i == OP_DEC)) |=> !flag_we_o[FL_C])
    else $error("increment or decrement touched carry");

  assert_logic_v_R5: assert property (@(posedge clk_i) disable iff (!rst_s)
    (take_byte && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=>
      (!flag_nxt_o[FL_V] && !flag_we_o[FL_C] && !flag_we_o[FL_H]))
    else $error("logic op flags wrong");

  assert_cmp_nowrite_R4: assert property (@(posedge clk_i) disable iff (!rst_s)
    (take_byte && (op_i == OP_CMP || op_i == OP_CMPC)) |=>
      (out_valid_o && !res_wr_o && flag_we_o == WE_ALL))
    else $error("compare wrote result or missed flags");

  assert_sign_R11: assert property (@(posedge clk_i) disable iff (!rst_s)
    (out_valid_o && flag_we_o[FL_S]) |->
      (flag_nxt_o[FL_S] == (flag_nxt_o[FL_N] ^ flag_nxt_o[FL_V])))
    else $error("S is not N xor V");
endmodule

// File: tb/alu8_flags_tb_top.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [4:0] op;
  logic [7:0] opa, opb, phi;
  logic       cin, zin;
  logic       busy, ovld, rwr;
  logic [7:0] rlo, rhi;
  logic [5:0] fl, we;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .pair_hi_i(phi), .c_in_i(cin), .z_in_i(zin),
    .busy_o(busy), .out_valid_o(ovld), .res_lo_o(rlo), .res_hi_o(rhi),
    .res_wr_o(rwr), .flag_nxt_o(fl), .flag_we_o(we)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at the falling edge, sample after the next rising edge
  task automatic issue(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic z, input logic [7:0] h);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; cin = c; zin = z; phi = h;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Flag vectors written as {H,S,V,N,Z,C}
  task automatic expect_byte(input string tag, input logic [7:0] r, input logic [5:0] e_we,
                             input logic [5:0] e_fl, input logic e_wr);
    check({tag, " valid"}, {15'd0, ovld}, 16'd1);
    check({tag, " result"}, {8'd0, rlo}, {8'd0, r});
    check({tag, " enables"}, {10'd0, we}, {10'd0, e_we});
    check({tag, " flags"}, {10'd0, fl & e_we}, {10'd0, e_fl});
    check({tag, " write"}, {15'd0, rwr}, {15'd0, e_wr});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0; phi = '0; cin = 0; zin = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R13 valid in reset", {15'd0, ovld}, 16'd0);
    check("R13 busy in reset", {15'd0, busy}, 16'd0);
    check("R13 enables in reset", {10'd0, we}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R13 valid after release", {15'd0, ovld}, 16'd0);
    check("R13 busy after release", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_addsub;
    issue(5'd0, 8'h3A, 8'h48, 1'b1, 1'b0, 8'h00);
    expect_byte("R2 ADD 3A+48", 8'h82, 6'h3F, 6'b101100, 1'b1);
    @(posedge clk); #1;
    check("R1 valid single pulse", {15'd0, ovld}, 16'd0);
    issue(5'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R2 ADC FF+00+1", 8'h00, 6'h3F, 6'b100011, 1'b1);
    issue(5'd2, 8'h10, 8'h20, 1'b0, 1'b0, 8'h00);
    expect_byte("R2 SUB 10-20", 8'hF0, 6'h3F, 6'b010101, 1'b1);
    issue(5'd2, 8'h80, 8'h01, 1'b0, 1'b0, 8'h00);
    expect_byte("R2 SUB 80-01 overflow", 8'h7F, 6'h3F, 6'b111000, 1'b1);
  endtask

  task automatic t_zchain;
    issue(5'd3, 8'h05, 8'h05, 1'b0, 1'b0, 8'h00);
    expect_byte("R3 SBC zero with z_in=0", 8'h00, 6'h3F, 6'b000000, 1'b1);
    issue(5'd3, 8'h05, 8'h04, 1'b1, 1'b1, 8'h00);
    expect_byte("R3 SBC zero with z_in=1", 8'h00, 6'h3F, 6'b000010, 1'b1);
    issue(5'd3, 8'h06, 8'h04, 1'b1, 1'b1, 8'h00);
    expect_byte("R3 SBC nonzero with z_in=1", 8'h01, 6'h3F, 6'b000000, 1'b1);
  endtask

  task automatic t_compare;
    issue(5'd5, 8'h12, 8'h12, 1'b0, 1'b1, 8'h00);
    expect_byte("R4 CPC equal", 8'h00, 6'h3F, 6'b000010, 1'b0);
    issue(5'd4, 8'h01, 8'h02, 1'b0, 1'b0, 8'h00);
    check("R4 CMP valid", {15'd0, ovld}, 16'd1);
    check("R4 CMP flags", {10'd0, fl}, {10'd0, 6'b110101});
    check("R4 CMP no write", {15'd0, rwr}, 16'd0);
  endtask

  task automatic t_logic;
    issue(5'd6, 8'hF0, 8'h8F, 1'b1, 1'b0, 8'h00);
    expect_byte("R5 AND", 8'h80, 6'b011110, 6'b010100, 1'b1);
    issue(5'd7, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R5 OR zero", 8'h00, 6'b011110, 6'b000010, 1'b1);
    issue(5'd8, 8'h55, 8'hAA, 1'b0, 1'b0, 8'h00);
    expect_byte("R5 XOR", 8'hFF, 6'b011110, 6'b010100, 1'b1);
  endtask

  task automatic t_unary;
    issue(5'd9, 8'h35, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R6 COM", 8'hCA, 6'b011111, 6'b010101, 1'b1);
    issue(5'd10, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R6 NEG 01", 8'hFF, 6'h3F, 6'b110101, 1'b1);
    issue(5'd10, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R6 NEG 80", 8'h80, 6'h3F, 6'b001101, 1'b1);
    issue(5'd10, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R6 NEG 00", 8'h00, 6'h3F, 6'b000010, 1'b1);
  endtask

  task automatic t_incdec;
    issue(5'd11, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R7 INC 7F", 8'h80, 6'b011110, 6'b001100, 1'b1);
    issue(5'd11, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R7 INC FF", 8'h00, 6'b011110, 6'b000010, 1'b1);
    issue(5'd12, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R7 DEC 80", 8'h7F, 6'b011110, 6'b011000, 1'b1);
    issue(5'd12, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R7 DEC 01", 8'h00, 6'b011110, 6'b000010, 1'b1);
  endtask

  task automatic t_shift;
    issue(5'd13, 8'h88, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R8 LSL 88", 8'h10, 6'h3F, 6'b111001, 1'b1);
    issue(5'd15, 8'h40, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R8 ROL 40 c=1", 8'h81, 6'h3F, 6'b001100, 1'b1);
    issue(5'd14, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R8 LSR 01", 8'h00, 6'b011111, 6'b011011, 1'b1);
    issue(5'd16, 8'h02, 8'h00, 1'b1, 1'b0, 8'h00);
    expect_byte("R8 ROR 02 c=1", 8'h81, 6'b011111, 6'b001100, 1'b1);
    issue(5'd17, 8'h81, 8'h00, 1'b0, 1'b0, 8'h00);
    expect_byte("R8 ASR 81", 8'hC0, 6'b011111, 6'b010101, 1'b1);
  endtask

  task automatic t_noflag;
    issue(5'd18, 8'h3C, 8'h00, 1'b1, 1'b1, 8'h00);
    expect_byte("R9 SWAP 3C", 8'hC3, 6'b000000, 6'b000000, 1'b1);
    issue(5'd19, 8'h12, 8'h00, 1'b1, 1'b1, 8'h00);
    expect_byte("R9 SER", 8'hFF, 6'b000000, 6'b000000, 1'b1);
  endtask

  task automatic word(input string tag, input logic [4:0] o, input logic [7:0] h,
                      input logic [7:0] l, input logic [7:0] k, input logic [15:0] r,
                      input logic [5:0] e_fl);
    issue(o, l, k, 1'b0, 1'b0, h);
    check({tag, " busy"}, {15'd0, busy}, 16'd1);
    check({tag, " no early valid"}, {15'd0, ovld}, 16'd0);
    @(posedge clk); #1;
    check({tag, " valid"}, {15'd0, ovld}, 16'd1);
    check({tag, " busy cleared"}, {15'd0, busy}, 16'd0);
    check({tag, " result"}, {rhi, rlo}, r);
    check({tag, " enables"}, {10'd0, we}, {10'd0, 6'b011111});
    check({tag, " flags"}, {10'd0, fl & 6'b011111}, {10'd0, e_fl});
  endtask

  task automatic t_word;
    word("R10 WADD 7FFF+1", 5'd20, 8'h7F, 8'hFF, 8'h01, 16'h8000, 6'b001100);
    word("R10 WSUB 0000-1", 5'd21, 8'h00, 8'h00, 8'h01, 16'hFFFF, 6'b010101);
    word("R10 WSUB 0005-5", 5'd21, 8'h00, 8'h05, 8'h05, 16'h0000, 6'b000010);
    word("R10 WADD FFFF+1", 5'd20, 8'hFF, 8'hFF, 8'h01, 16'h0000, 6'b000011);
    word("R10 WADD 0010+1 low nonzero", 5'd20, 8'h00, 8'h10, 8'h01, 16'h0011, 6'b000000);
  endtask

  task automatic t_busy_ignore;
    issue(5'd20, 8'h34, 8'h02, 1'b0, 1'b0, 8'h12);
    check("R12 busy set", {15'd0, busy}, 16'd1);
    @(negedge clk);
    in_valid = 1'b1; op = 5'd19; opa = 8'h00;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R12 word result kept", {rhi, rlo}, 16'h1236);
    @(posedge clk); #1;
    check("R12 request during busy dropped", {15'd0, ovld}, 16'd0);
    check("R12 result unchanged", {rhi, rlo}, 16'h1236);
  endtask

  task automatic t_reserved;
    issue(5'd25, 8'h77, 8'h11, 1'b1, 1'b1, 8'h00);
    check("R12 reserved valid", {15'd0, ovld}, 16'd1);
    check("R12 reserved enables", {10'd0, we}, 16'd0);
    check("R12 reserved write", {15'd0, rwr}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_addsub();
    t_zchain();
    t_compare();
    t_logic();
    t_unary();
    t_incdec();
    t_shift();
    t_noflag();
    t_word();
    t_busy_ignore();
    t_reserved();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule